// File: doc/BRIEF.md
# Overlapping 11011 serial pattern detector

This block watches a serial bit stream that advances one bit per clock. It raises a single-cycle match flag whenever the five most recent bits, oldest first, read 1, 1, 0, 1, 1. Matches may overlap: the last two ones of one match count as the first two ones of the next.

The flag is a Mealy output. It is formed combinationally from the held state and the bit on the input now, so it is valid in the same cycle as the fifth bit of the pattern. The block keeps its history in five states, held in a three-bit register. The register's encoding places states entered on a zero at even codes and states entered on a one at odd codes. A synchronous, active-high reset clears the history.

Top module: `pat11011_det`

## Requirements
- R1: In the first cycle after reset is released, the match flag is 0 for either input value, and the stream 1011 fed straight after reset gives no match.
- R2: Counting only bits sampled since reset, the match flag is 1 in a cycle exactly when that cycle's input bit and the four bits before it form 11011, oldest first.
- R3: Matches overlap. The stream 11011011 gives a match on its fifth and on its eighth bit.
- R4: A run of more than two ones followed by 011 still matches. For example, 1111011 matches on its last bit.
- R5: A zero in the wrong position breaks the pattern. The streams 110011 and 11010 followed by 11 give no match.
- R6: Asserting reset in the middle of a partial pattern discards it. The stream 1101, then reset, then 1 gives no match.
- R7: The match flag is never 1 in a cycle whose input bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state advances on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit, one per clock |
| hit | output | 1 | Combinational match flag |

## Verification
The hard case is a long chain of overlapping and near-miss patterns. The machine must return to the "11 seen" state after a match, and it must stay there while more ones arrive. A single isolated pattern never reaches either path. Directed streams build these chains on purpose, including one that carries a reset in the middle of a partial pattern. A long random stream then runs against a five-bit shift-register model of the input history, so that every sequence of states is reached many times.

// File: rtl/pat11011_det.sv
module pat11011_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  localparam logic [2:0] ST_A = 3'b000;
  localparam logic [2:0] ST_B = 3'b001;
  localparam logic [2:0] ST_C = 3'b011;
  localparam logic [2:0] ST_D = 3'b100;
  localparam logic [2:0] ST_E = 3'b101;

  logic [2:0] state, state_nx;

  always_comb begin
    case (state)
      ST_A:    state_nx = din ? ST_B : ST_A;
      ST_B:    state_nx = din ? ST_C : ST_A;
      ST_C:    state_nx = din ? ST_C : ST_D;
      ST_D:    state_nx = din ? ST_E : ST_A;
      ST_E:    state_nx = din ? ST_C : ST_A;
      default: state_nx = ST_A;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_A;
    else     state <= state_nx;
  end

  assign hit = (state == ST_E) && din;

  a_r7_no_hit_on_zero: assert property (@(posedge clk) disable iff (rst)
    hit |-> din);

  a_r2_hit_history: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(din, 1) && !$past(din, 2) && $past(din, 3) && $past(din, 4)));

  a_r3_resume_after_hit: assert property (@(posedge clk) disable iff (rst)
    hit |=> (state == ST_C));

  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (state == ST_A));

  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    (state != 3'b010) && (state != 3'b110) && (state != 3'b111));
endmodule

// File: tb/pat11011_det_test.sv
module pat11011_det_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic hit;

  int total = 0;
  int bad = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [3:0] hist = 4'b0;
  int seen = 0;
  bit done = 1'b0;

  pat11011_det uut (.clk(clk), .rst(rst), .din(din), .hit(hit));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic send(input bit b, input string tag);
    bit e;
    @(negedge clk);
    rst = 1'b0;
    din = b;
    e = (seen >= 4) && ({hist, b} == 5'b11011);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    hist = {hist[2:0], b};
    seen++;
  endtask

  task automatic send_str(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) send(s[i] == "1", tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    hist = 4'b0;
    seen = 0;
  endtask

  initial begin : monitor
    bit e;
    string t;
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if (hit !== e) begin
          bad++;
          $display("FAIL %s: hit=%b expected=%b", t, hit, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: expired=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    bit b;
    do_reset();
    do_reset();
    send(1'b1, "R1");
    do_reset();
    send(1'b0, "R1");
    do_reset();
    send_str("1011", "R1");
    do_reset();
    send_str("11011", "R2");
    send_str("0011011", "R2");
    do_reset();
    send_str("11011011", "R3");
    send_str("011011011", "R3");
    do_reset();
    send_str("1111011", "R4");
    send_str("01111111011", "R4");
    do_reset();
    send_str("110011", "R5");
    do_reset();
    send_str("1101011", "R5");
    do_reset();
    send_str("1101", "R6");
    do_reset();
    send_str("1", "R6");
    send_str("1011", "R6");
    do_reset();
    send_str("000110110000", "R7");
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      b = ($urandom_range(0, 3) != 0);
      send(b, "R2");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule